// File: doc/BRIEF.md
# Dual-Lane SECDED Checker for Wide Flash Reads

This block sits between a read requester and a nonvolatile array whose rows are 128 bits wide. Every request fetches a whole aligned line. The line is split into a lower and an upper 64-bit half, and each half carries its own 8-bit check byte. Two extended Hamming decoders examine the halves side by side. The requested half is returned to the requester, with a single flipped bit put right. Sticky status flags record correctable and uncorrectable events.

An uncorrectable error in either half sets the uncorrectable flag and asserts the non-maskable interrupt request. This happens even when the requester asked for the other, healthy half. The block also records the line address of the most recent faulty line and keeps a saturating count of corrected halves. Checking runs only while a 4-bit key register holds a fixed key value. The array itself is modelled as a synchronous port that answers one cycle after it is asked.

Top module: `flash_ecc_checker`

## Requirements
- R1: A request on `rd_req` is passed to the array in the same cycle on `mem_rd`/`mem_line` (`mem_line` = `rd_addr[LINE_AW:1]`). The array answers in the next cycle. `rsp_valid` is high exactly two cycles after `rd_req`. `rd_addr[0]` selects the half: 0 returns line bits [63:0], 1 returns bits [127:64].
- R2: Code definition. Codeword positions 1..71 exclude the power-of-two positions. Data bit k goes to the k-th remaining position in rising order, starting at 3. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check byte bit 7 makes the XOR of all 72 bits even. `mem_chk[7:0]` protects the lower half and `mem_chk[15:8]` the upper half. An error-free line is returned unchanged.
- R3: When one bit of a half's 72-bit codeword is flipped (a data, check or parity bit), that half is returned with its original data.
- R4: Two flipped bits in either half set the uncorrectable flag, whichever half was requested. `nmi_req` stays high for as long as the flag is set.
- R5: A half with one flipped bit sets the single-error flag. The count (config offset 3) rises by the number of such halves in the line (0, 1 or 2) and holds at 65535.
- R6: Config offset 0 bits [3:0] hold the enable key. The reset value is 0xA. With any other value, raw data is returned, and flags, count and captured address do not change.
- R7: Offset 1 reads {uncorrectable, single} in bits [1:0]. Writing 1 to a bit clears it, and otherwise the flags never fall. An error arriving in the same cycle as the clear leaves the flag set.
- R8: Offset 2 holds the line address of the last read with any error in either half.
- R9: After reset `rsp_valid`, `nmi_req`, both flags, the count and the captured address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| rd_addr | input | LINE_AW+1 | Line address in upper bits, half select in bit 0 |
| mem_rd | output | 1 | Array read strobe |
| mem_line | output | LINE_AW | Array line address |
| mem_data | input | 128 | Array line data, one cycle after strobe |
| mem_chk | input | 16 | Check bytes, lower half in [7:0] |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | 64 | Selected, corrected half |
| nmi_req | output | 1 | Non-maskable interrupt request |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config offset |
| cfg_wdata | input | 4 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr` |

## Verification
Clean lines confirm the encoding and the half selection. Single flips are placed at random in data, check and parity positions, and then in one half or both, which separates repair in the requested half from counting in the other half. Double flips are placed only in the half that was not requested, which exposes any design that flags by half rather than by line. Mixed lines, clears timed to land in the same cycle as a new error, reads with the key removed, and a long burst of lines with two correctable halves each cover priority, the off state and saturation of the count.

// File: rtl/flash_ecc_checker.sv
module flash_ecc_checker #(
  parameter int          LINE_AW = 12,
  parameter int          CNT_W   = 16,
  parameter logic [3:0]  EN_KEY  = 4'hA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [LINE_AW:0]   rd_addr,
  output logic               mem_rd,
  output logic [LINE_AW-1:0] mem_line,
  input  logic [127:0]       mem_data,
  input  logic [15:0]        mem_chk,
  output logic               rsp_valid,
  output logic [63:0]        rsp_data,
  output logic               nmi_req,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [3:0]         cfg_wdata,
  output logic [31:0]        cfg_rdata
);
  localparam int HALF_W = 64;
  localparam int CHK_W  = 8;
  localparam int SYN_W  = CHK_W - 1;
  localparam int LANES  = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [HALF_W-1:0][SYN_W-1:0] pos_table();
    logic [HALF_W-1:0][SYN_W-1:0] t;
    int k;
    t = '0;
    k = 0;
    for (int p = 3; p < (1 << SYN_W); p++)
      if (((p & (p - 1)) != 0) && k < HALF_W) begin
        t[k] = SYN_W'(p);
        k++;
      end
    return t;
  endfunction

  localparam logic [HALF_W-1:0][SYN_W-1:0] POS = pos_table();

  logic               s1_vld, s1_half;
  logic [LINE_AW-1:0] s1_line;
  logic [3:0]         en_q;
  logic               sb_flag, unc_flag;
  logic [LINE_AW-1:0] fail_line;
  logic [CNT_W-1:0]   sb_cnt;
  logic               chk_on;
  logic [LANES-1:0]   ln_sb, ln_unc;
  logic [LANES-1:0][HALF_W-1:0] ln_fix;

  assign mem_rd   = rd_req;
  assign mem_line = rd_addr[LINE_AW:1];
  assign chk_on   = (en_q == EN_KEY);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] d, fix;
    logic [CHK_W-1:0]  c;
    logic [SYN_W-1:0]  syn;
    logic              par, hit, pow2, fixable;

    assign d = mem_data[g*HALF_W +: HALF_W];
    assign c = mem_chk[g*CHK_W +: CHK_W];
    assign par = ^{d, c};

    always_comb begin
      syn = c[SYN_W-1:0];
      for (int k = 0; k < HALF_W; k++)
        if (d[k]) syn = syn ^ POS[k];
    end

    always_comb begin
      fix = d;
      hit = 1'b0;
      for (int k = 0; k < HALF_W; k++)
        if (POS[k] == syn) begin
          fix[k] = ~d[k];
          hit    = 1'b1;
        end
    end

    assign pow2    = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
    assign fixable = par && ((syn == '0) || pow2 || hit);
    assign ln_sb[g]  = chk_on && fixable;
    assign ln_unc[g] = chk_on && (syn != '0 || par) && !fixable;
    assign ln_fix[g] = (chk_on && par && hit) ? fix : d;
  end

  logic             set_sb, set_unc;
  logic [1:0]       clr;
  logic [CNT_W:0]   cnt_sum;

  assign set_sb  = s1_vld && (|ln_sb);
  assign set_unc = s1_vld && (|ln_unc);
  assign clr     = (cfg_we && cfg_addr == 2'd1) ? cfg_wdata[1:0] : 2'b00;
  assign cnt_sum = {1'b0, sb_cnt} + {{CNT_W{1'b0}}, s1_vld & ln_sb[0]}
                                  + {{CNT_W{1'b0}}, s1_vld & ln_sb[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_half   <= 1'b0;
      s1_line   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      en_q      <= EN_KEY;
      sb_flag   <= 1'b0;
      unc_flag  <= 1'b0;
      fail_line <= '0;
      sb_cnt    <= '0;
    end else begin
      s1_vld    <= rd_req;
      s1_half   <= rd_addr[0];
      s1_line   <= rd_addr[LINE_AW:1];
      rsp_valid <= s1_vld;
      if (s1_vld) rsp_data <= ln_fix[s1_half];
      if (cfg_we && cfg_addr == 2'd0) en_q <= cfg_wdata;
      sb_flag   <= (sb_flag  & ~clr[0]) | set_sb;
      unc_flag  <= (unc_flag & ~clr[1]) | set_unc;
      if (set_sb || set_unc) fail_line <= s1_line;
      sb_cnt    <= cnt_sum[CNT_W] ? CNT_MAX : cnt_sum[CNT_W-1:0];
    end
  end

  assign nmi_req = unc_flag;

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {28'd0, en_q};
      2'd1:    cfg_rdata = {30'd0, unc_flag, sb_flag};
      2'd2:    cfg_rdata = 32'(fail_line);
      default: cfg_rdata = 32'(sb_cnt);
    endcase
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ##2 rsp_valid);
  a_r4_nmi_on_unc: assert property (@(posedge clk) disable iff (!rst_n)
    set_unc |=> nmi_req);
  a_r7_unc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_flag && !clr[1]) |=> unc_flag);
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    set_sb |=> sb_flag);
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !chk_on) |=> ($stable(sb_cnt) && $stable(fail_line)));
  a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_cnt == CNT_MAX) |=> (sb_cnt == CNT_MAX));
endmodule

// File: tb/test_flash_ecc_checker.sv
module test_flash_ecc_checker;
  localparam int CLK_NS = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 1'b0;
  logic [AW:0] rd_addr = '0;
  logic mem_rd;
  logic [AW-1:0] mem_line;
  logic [127:0] mem_data = '0;
  logic [15:0] mem_chk = '0;
  logic rsp_valid, nmi_req;
  logic [63:0] rsp_data;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  always #(CLK_NS/2) clk = ~clk;

  flash_ecc_checker #(.LINE_AW(AW)) i_flash_ecc_checker (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .mem_rd(mem_rd), .mem_line(mem_line), .mem_data(mem_data), .mem_chk(mem_chk),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nmi_req(nmi_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] encode(input logic [63:0] d);
    logic [6:0] c = '0;
    int k = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) == 0) continue;
      if (d[k]) c = c ^ 7'(p);
      k++;
    end
    return {^d ^ ^c, c};
  endfunction

  function automatic logic [71:0] corrupt(input logic [63:0] d, input int ne);
    logic [71:0] cw = {encode(d), d};
    int i = $urandom % 72;
    int j = (i + 1 + ($urandom % 71)) % 72;
    if (ne >= 1) cw[i] = ~cw[i];
    if (ne >= 2) cw[j] = ~cw[j];
    return cw;
  endfunction

  // stimulus-side line description
  logic [127:0] cur_raw = '0, cur_clean = '0;
  logic [15:0] cur_chk = '0;
  int cur_elo = 0, cur_ehi = 0;

  always @(posedge clk) if (mem_rd) begin
    mem_data <= cur_raw;
    mem_chk  <= cur_chk;
  end

  // reference model
  logic [3:0] m_en;
  logic m_sb, m_unc;
  logic [AW-1:0] m_fail;
  int m_cnt;
  logic s1_v, s1_h;
  logic [AW-1:0] s1_line;
  logic [127:0] s1_raw, s1_clean;
  int s1_elo, s1_ehi;
  logic ex_v, ex_dchk;
  logic [63:0] ex_data;
  string ex_tag;
  bit on, set_unc;
  int nsb, e;
  logic [1:0] clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 4'hA; m_sb = 0; m_unc = 0; m_fail = '0; m_cnt = 0;
      s1_v = 0; s1_h = 0; s1_line = '0; s1_raw = '0; s1_clean = '0;
      s1_elo = 0; s1_ehi = 0; ex_v = 0; ex_dchk = 0; ex_data = '0; ex_tag = "";
    end else begin
      on = (m_en == 4'hA);
      ex_v = s1_v; ex_dchk = 0; nsb = 0; set_unc = 0;
      if (s1_v) begin
        e = s1_h ? s1_ehi : s1_elo;
        if (!on) begin
          ex_data = s1_h ? s1_raw[127:64] : s1_raw[63:0]; ex_dchk = 1;
          ex_tag = "R6 raw data while checking off";
        end else if (e <= 1) begin
          ex_data = s1_h ? s1_clean[127:64] : s1_clean[63:0]; ex_dchk = 1;
          ex_tag = (e == 0) ? "R2 clean line data" : "R3 corrected data";
        end
        if (on) begin
          nsb = int'(s1_elo == 1) + int'(s1_ehi == 1);
          set_unc = (s1_elo == 2) || (s1_ehi == 2);
        end
      end
      clr = (cfg_we && cfg_addr == 2'd1) ? cfg_wdata[1:0] : 2'b00;
      m_sb  = (m_sb  && !clr[0]) || (nsb > 0);
      m_unc = (m_unc && !clr[1]) || set_unc;
      if (nsb > 0 || set_unc) m_fail = s1_line;
      m_cnt = (m_cnt + nsb > 65535) ? 65535 : m_cnt + nsb;
      if (cfg_we && cfg_addr == 2'd0) m_en = cfg_wdata;
      s1_v = rd_req; s1_h = rd_addr[0]; s1_line = rd_addr[AW:1];
      s1_raw = cur_raw; s1_clean = cur_clean; s1_elo = cur_elo; s1_ehi = cur_ehi;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    check(rsp_valid === ex_v, "R1 rsp_valid timing", 128'(rsp_valid), 128'(ex_v));
    if (ex_v && ex_dchk)
      check(rsp_data === ex_data, ex_tag, 128'(rsp_data), 128'(ex_data));
    check(nmi_req === m_unc, "R4 nmi_req level", 128'(nmi_req), 128'(m_unc));
    case (cfg_addr)
      2'd0: check(cfg_rdata === {28'd0, m_en}, "R6 enable key readback", 128'(cfg_rdata), 128'(m_en));
      2'd1: check(cfg_rdata === {30'd0, m_unc, m_sb}, "R7 status flags", 128'(cfg_rdata), 128'({m_unc, m_sb}));
      2'd2: check(cfg_rdata === 32'(m_fail), "R8 captured line address", 128'(cfg_rdata), 128'(m_fail));
      default: check(cfg_rdata === 32'(m_cnt), "R5 single error count", 128'(cfg_rdata), 128'(m_cnt));
    endcase
  end

  int rot = 0;

  task automatic cyc(input bit do_rd, input int line, input bit h, input int elo, input int ehi,
                     input bit do_wr, input logic [1:0] wa, input logic [3:0] wd);
    logic [63:0] lo, hi;
    logic [71:0] clo, chi;
    @(posedge clk); #1;
    rd_req = do_rd;
    if (do_rd) begin
      lo = {$urandom, $urandom}; hi = {$urandom, $urandom};
      clo = corrupt(lo, elo); chi = corrupt(hi, ehi);
      rd_addr = {AW'(line), h};
      cur_clean = {hi, lo};
      cur_raw = {chi[63:0], clo[63:0]};
      cur_chk = {chi[71:64], clo[71:64]};
      cur_elo = elo; cur_ehi = ehi;
    end
    cfg_we = do_wr;
    cfg_wdata = wd;
    cfg_addr = do_wr ? wa : 2'(rot);
    rot++;
  endtask

  task automatic rd(input int line, input bit h, input int elo, input int ehi);
    cyc(1, line, h, elo, ehi, 0, 2'd0, 4'd0);
  endtask

  task automatic wr(input logic [1:0] wa, input logic [3:0] wd);
    cyc(0, 0, 0, 0, 0, 1, wa, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 2'd0, 4'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && nmi_req === 1'b0, "R9 reset outputs", 128'({rsp_valid, nmi_req}), 128'(0));
    // R1 R2: clean lines, both halves
    for (int i = 0; i < 20; i++) rd(i * 37, i[0], 0, 0);
    idle(3);
    // R3 R5: single flips in requested half, other half, both halves
    for (int i = 0; i < 30; i++) rd(100 + i, i[0], (i % 3 != 1) ? 1 : 0, (i % 3 != 0) ? 1 : 0);
    idle(3);
    wr(2'd1, 4'b0001);
    idle(2);
    // R4: double flip in the half not requested
    rd(700, 1'b0, 0, 2);
    idle(4);
    wr(2'd1, 4'b0010);
    idle(2);
    rd(701, 1'b1, 2, 0);
    idle(4);
    wr(2'd1, 4'b0011);
    idle(2);
    // mixed single + double, R8 capture
    rd(702, 1'b0, 1, 2);
    rd(703, 1'b1, 2, 1);
    idle(3);
    // R7: clear landing in same cycle as a new error
    wr(2'd1, 4'b0011);
    rd(800, 1'b0, 2, 0);
    wr(2'd1, 4'b0010);
    idle(3);
    rd(801, 1'b1, 0, 1);
    wr(2'd1, 4'b0011);
    idle(3);
    wr(2'd1, 4'b0011);
    idle(2);
    // R6: key removed, reads return raw data and record nothing
    wr(2'd0, 4'h5);
    for (int i = 0; i < 12; i++) rd(900 + i, i[0], i % 3, (i + 1) % 3);
    idle(3);
    wr(2'd0, 4'hA);
    idle(2);
    // random mix with random clears
    for (int i = 0; i < 400; i++)
      cyc($urandom % 4 != 0, $urandom % 4096, 1'($urandom), $urandom % 3, $urandom % 3,
          ($urandom % 9 == 0), 2'd1, 4'($urandom % 4));
    idle(3);
    wr(2'd1, 4'b0011);
    // R5: saturation with two correctable halves per line
    for (int i = 0; i < 32800; i++) rd(i % 4096, i[0], 1, 1);
    idle(4);
    for (int i = 0; i < 4; i++) rd(5, 1'b0, 1, 0);
    idle(6);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule